// File: doc/BRIEF.md
# Serial Loader Status Register Unit

This unit keeps the secondary status byte of a byte-serial boot-loader command port. Four sources write it: the download engine reports a finished update, the checksum unit reports whether a downloaded image summed correctly, the ID comparator reports whether the host gave the right ID code, and the unit's own inter-byte timer reports a stalled transfer. Each source delivers a one-cycle event pulse with a result bit. Power-on clears the byte. A warm reset leaves it as it was.

The unit also decodes the incoming command byte stream. A read-status command returns two bytes through a valid/ready output: first the primary status byte from the neighbouring block, then this byte. A clear-status command zeroes this byte. Every other opcode is a data command with a fixed number of payload bytes. All data commands except one open opcode are ID-protected. A protected opcode that arrives before the ID has been verified is dropped, and the next byte is decoded as a new command. While payload bytes are being received, a gap of too many idle cycles sets the timeout flag, discards the partial transfer and returns the decoder to command wait.

Top module: `ldr_status_unit`

## Requirements
- R1: While `por_ni` is low, `stat_o` is 0x00. Bits 6, 5 and 0 always read 0.
- R2: While `rst_ni` is low with `por_ni` high, `stat_o` does not change, even if a clear command (0x50) is presented during that time. After release, the decoder is back in command wait.
- R3: A `upd_done_i` pulse sets bit 7. The change is visible on `stat_o` after the clock edge that samples the pulse.
- R4: A `sum_evt_i` pulse writes `sum_ok_i` into bit 4: 1 means match, 0 means mismatch. It is visible after the sampling edge.
- R5: An `id_evt_i` pulse writes bits 3:2. They become 11 (verified) when `id_ok_i` is 1 and 01 (mismatch) otherwise. The value 00 means not yet verified.
- R6: Command 0x70 captures the primary status and this byte as they stand in the accept cycle. It then drives them on `st_data_o` in that order. `cmd_ready_o` stays low until the second byte is taken.
- R7: Command 0x50 clears the byte to 0x00 at the edge that accepts it. It overrides any set event in the same cycle.
- R8: Any other opcode starts a data command of `PAY_BYTES` payload bytes. One cycle after the last payload byte is accepted, `go_o` pulses for one cycle with `go_op_o` equal to the opcode.
- R9: Every data opcode except `OP_OPEN` (default 0xF5) is refused unless bits 3:2 read 11. A refused opcode produces no `go_o`, and the following byte is decoded as a command.
- R10: During payload reception, `TMO_CYCLES` consecutive cycles without an accepted byte set bit 1 at the last of those edges. The transfer is dropped with no `go_o`. A byte accepted at that edge takes priority. Idle time in command wait never sets bit 1.
- R11: Each output byte stays on `st_data_o` with `st_valid_o` high until a cycle with `st_ready_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous; clears status and decoder |
| rst_ni | input | 1 | Warm reset, active low, asynchronous; decoder only |
| cmd_valid_i | input | 1 | Command/payload byte valid |
| cmd_data_i | input | 8 | Command/payload byte |
| cmd_ready_o | output | 1 | Byte can be accepted |
| prim_stat_i | input | 8 | Primary status byte from neighbouring block |
| st_valid_o | output | 1 | Status output byte valid |
| st_data_o | output | 8 | Status output byte |
| st_ready_i | input | 1 | Status output byte taken |
| upd_done_i | input | 1 | Update-completed event |
| sum_evt_i | input | 1 | Checksum result event |
| sum_ok_i | input | 1 | Checksum matched |
| id_evt_i | input | 1 | ID check result event |
| id_ok_i | input | 1 | ID matched |
| go_o | output | 1 | Data command dispatch pulse |
| go_op_o | output | 8 | Opcode of dispatched command |
| stat_o | output | 8 | Current status byte |

## Verification
Status events, clears and the timeout flag all land on `stat_o` one edge after they are sampled. The bench drives inputs on falling edges and checks one falling edge later. A read puts its first byte out right after the edge that accepts 0x70, and each following byte appears one edge after a handshake. The bench checks each byte at the falling edge that follows. `go_o` is checked at the falling edge after the last payload byte, and again one cycle later to confirm it has dropped. For the timeout, the bench counts idle falling edges after the last accepted byte. It expects bit 1 to stay clear after `TMO_CYCLES-1` of them and to be set after `TMO_CYCLES`. A byte sent into that final cycle must reset the count instead.

// File: rtl/ldr_stat_pkg.sv
package ldr_stat_pkg;
  localparam int BYTE_W = 8;
  localparam int B_UPD = 7;
  localparam int B_SUM = 4;
  localparam int B_IDH = 3;
  localparam int B_IDL = 2;
  localparam int B_TMO = 1;
  localparam logic [BYTE_W-1:0] RSV_MASK = 8'b0110_0001;
  localparam logic [1:0] ID_BAD = 2'b01;
  localparam logic [1:0] ID_OK  = 2'b11;

  typedef enum logic [1:0] {S_CMD, S_PAY, S_RD0, S_RD1} fsm_e;

  typedef struct packed {
    logic upd;
    logic sum_evt;
    logic sum_ok;
    logic id_evt;
    logic id_ok;
    logic tmo;
  } stat_evt_t;
endpackage

// File: rtl/ldr_tmo_cnt.sv
module ldr_tmo_cnt #(
  parameter int TMO_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && !kick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!run_i || kick_i || expire_o) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  // R10
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !kick_i && !expire_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R10
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i || kick_i) |=> (cnt_q == '0));
endmodule

// File: rtl/ldr_stat_reg.sv
module ldr_stat_reg
  import ldr_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  stat_evt_t         evt_i,
  output logic [BYTE_W-1:0] stat_o
);
  logic [BYTE_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (evt_i.upd)     stat_d[B_UPD] = 1'b1;
    if (evt_i.sum_evt) stat_d[B_SUM] = evt_i.sum_ok;
    if (evt_i.id_evt)  stat_d[B_IDH:B_IDL] = evt_i.id_ok ? ID_OK : ID_BAD;
    if (evt_i.tmo)     stat_d[B_TMO] = 1'b1;
    if (clr_i)         stat_d = '0;
    stat_d &= ~RSV_MASK;
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)   stat_q <= '0;
    else if (en_i) stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  // R7
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (en_i && clr_i) |=> (stat_o == '0));

  // R3
  upd_set_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (en_i && evt_i.upd && !clr_i) |=> stat_o[B_UPD]);

  // R4
  sum_wr_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (en_i && evt_i.sum_evt && !clr_i) |=> (stat_o[B_SUM] == $past(evt_i.sum_ok)));

  // R5
  id_wr_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (en_i && evt_i.id_evt && !clr_i) |=>
      (stat_o[B_IDH:B_IDL] == ($past(evt_i.id_ok) ? ID_OK : ID_BAD)));
endmodule

// File: rtl/ldr_cmd_fsm.sv
module ldr_cmd_fsm
  import ldr_stat_pkg::*;
#(
  parameter int              PAY_BYTES = 3,
  parameter logic [BYTE_W-1:0] OP_RD   = 8'h70,
  parameter logic [BYTE_W-1:0] OP_CLR  = 8'h50,
  parameter logic [BYTE_W-1:0] OP_OPEN = 8'hF5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [BYTE_W-1:0] cmd_data_i,
  output logic              cmd_ready_o,
  input  logic [BYTE_W-1:0] prim_i,
  input  logic [BYTE_W-1:0] stat_i,
  input  logic              id_pass_i,
  input  logic              expire_i,
  output logic              st_valid_o,
  output logic [BYTE_W-1:0] st_data_o,
  input  logic              st_ready_i,
  output logic              clr_o,
  output logic              tmo_o,
  output logic              run_o,
  output logic              kick_o,
  output logic              live_o,
  output logic              go_o,
  output logic [BYTE_W-1:0] go_op_o
);
  localparam int PW = $clog2(PAY_BYTES + 1);
  localparam logic [PW-1:0] PAY_LAST = PW'(PAY_BYTES - 1);

  fsm_e              state_q, state_d;
  logic              live_q, go_q;
  logic [BYTE_W-1:0] snap_p_q, snap_s_q, op_q;
  logic [PW-1:0]     pay_q;
  logic              acc, is_rd, is_clr, is_open, pay_last, take_data;

  assign cmd_ready_o = live_q && (state_q == S_CMD || state_q == S_PAY);
  assign acc       = cmd_valid_i && cmd_ready_o;
  assign is_rd     = (cmd_data_i == OP_RD);
  assign is_clr    = (cmd_data_i == OP_CLR);
  assign is_open   = (cmd_data_i == OP_OPEN);
  assign pay_last  = (pay_q == PAY_LAST);
  assign take_data = !is_rd && !is_clr && (is_open || id_pass_i);

  assign clr_o  = acc && state_q == S_CMD && is_clr;
  assign run_o  = (state_q == S_PAY);
  assign kick_o = acc;
  assign tmo_o  = run_o && expire_i;
  assign live_o = live_q;

  assign st_valid_o = (state_q == S_RD0 || state_q == S_RD1);
  assign st_data_o  = (state_q == S_RD0) ? snap_p_q : snap_s_q;
  assign go_o       = go_q;
  assign go_op_o    = op_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_CMD: if (acc) begin
        if (is_rd)          state_d = S_RD0;
        else if (take_data) state_d = S_PAY;
      end
      S_PAY: begin
        if (acc) begin
          if (pay_last) state_d = S_CMD;
        end else if (expire_i) state_d = S_CMD;
      end
      S_RD0: if (st_ready_i) state_d = S_RD1;
      S_RD1: if (st_ready_i) state_d = S_CMD;
      default: state_d = S_CMD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_CMD;
      live_q   <= 1'b0;
      go_q     <= 1'b0;
      snap_p_q <= '0;
      snap_s_q <= '0;
      op_q     <= '0;
      pay_q    <= '0;
    end else begin
      state_q <= state_d;
      live_q  <= 1'b1;
      go_q    <= (state_q == S_PAY) && acc && pay_last;
      if (state_q == S_CMD && acc) begin
        if (is_rd) begin
          snap_p_q <= prim_i;
          snap_s_q <= stat_i;
        end else if (take_data) begin
          op_q  <= cmd_data_i;
          pay_q <= '0;
        end
      end else if (state_q == S_PAY && acc) begin
        pay_q <= pay_last ? '0 : pay_q + 1'b1;
      end
    end
  end

  // R11
  st_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_o && !st_ready_i) |=> (st_valid_o && $stable(st_data_o)));

  // R6
  rd_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_o |-> !cmd_ready_o);

  // R9
  prot_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CMD && acc && !is_rd && !is_clr && !is_open && !id_pass_i)
      |=> (state_q == S_CMD && !go_o));

  // R10
  tmo_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> (state_q == S_CMD && !go_o));

  // R8
  go_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> !go_o);
endmodule

// File: rtl/ldr_status_unit.sv
module ldr_status_unit
  import ldr_stat_pkg::*;
#(
  parameter int              TMO_CYCLES = 16,
  parameter int              PAY_BYTES  = 3,
  parameter logic [BYTE_W-1:0] OP_RD    = 8'h70,
  parameter logic [BYTE_W-1:0] OP_CLR   = 8'h50,
  parameter logic [BYTE_W-1:0] OP_OPEN  = 8'hF5
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [BYTE_W-1:0] cmd_data_i,
  output logic              cmd_ready_o,
  input  logic [BYTE_W-1:0] prim_stat_i,
  output logic              st_valid_o,
  output logic [BYTE_W-1:0] st_data_o,
  input  logic              st_ready_i,
  input  logic              upd_done_i,
  input  logic              sum_evt_i,
  input  logic              sum_ok_i,
  input  logic              id_evt_i,
  input  logic              id_ok_i,
  output logic              go_o,
  output logic [BYTE_W-1:0] go_op_o,
  output logic [BYTE_W-1:0] stat_o
);
  logic      core_rst_n;
  logic      clr, tmo, run, kick, live, expire, id_pass;
  stat_evt_t evt;

  // decoder restarts on either reset; status only on power-on
  assign core_rst_n = rst_ni & por_ni;
  assign id_pass    = (stat_o[B_IDH:B_IDL] == ID_OK);

  assign evt = '{upd: upd_done_i, sum_evt: sum_evt_i, sum_ok: sum_ok_i,
                 id_evt: id_evt_i, id_ok: id_ok_i, tmo: tmo};

  ldr_tmo_cnt #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk_i   (clk_i),
    .rst_ni  (core_rst_n),
    .run_i   (run),
    .kick_i  (kick),
    .expire_o(expire)
  );

  ldr_cmd_fsm #(
    .PAY_BYTES(PAY_BYTES), .OP_RD(OP_RD), .OP_CLR(OP_CLR), .OP_OPEN(OP_OPEN)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (core_rst_n),
    .cmd_valid_i(cmd_valid_i),
    .cmd_data_i (cmd_data_i),
    .cmd_ready_o(cmd_ready_o),
    .prim_i     (prim_stat_i),
    .stat_i     (stat_o),
    .id_pass_i  (id_pass),
    .expire_i   (expire),
    .st_valid_o (st_valid_o),
    .st_data_o  (st_data_o),
    .st_ready_i (st_ready_i),
    .clr_o      (clr),
    .tmo_o      (tmo),
    .run_o      (run),
    .kick_o     (kick),
    .live_o     (live),
    .go_o       (go_o),
    .go_op_o    (go_op_o)
  );

  ldr_stat_reg u_reg (
    .clk_i (clk_i),
    .por_ni(por_ni),
    .en_i  (live),
    .clr_i (clr),
    .evt_i (evt),
    .stat_o(stat_o)
  );

  // R2
  warm_keep_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    !rst_ni |=> $stable(stat_o));

  // R1
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    ((stat_o & RSV_MASK) == '0));
endmodule

// File: tb/ldr_status_unit_tb.sv
`timescale 1ns/1ps
module ldr_status_unit_tb;
  localparam int TMO = 16;
  localparam int PAY = 3;
  localparam logic [7:0] OP_RD = 8'h70, OP_CLR = 8'h50, OP_OPEN = 8'hF5;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_data = '0;
  logic       cmd_ready;
  logic [7:0] prim = '0;
  logic       st_valid, st_ready = 1'b0;
  logic [7:0] st_data;
  logic       upd = 1'b0, sum_evt = 1'b0, sum_ok = 1'b0, id_evt = 1'b0, id_ok = 1'b0;
  logic       go;
  logic [7:0] go_op, stat;

  int errs = 0, checks = 0;
  logic [7:0] exp_stat = '0;

  always #2.5 clk = ~clk;

  ldr_status_unit #(.TMO_CYCLES(TMO), .PAY_BYTES(PAY)) u_dut (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data), .cmd_ready_o(cmd_ready),
    .prim_stat_i(prim), .st_valid_o(st_valid), .st_data_o(st_data),
    .st_ready_i(st_ready), .upd_done_i(upd), .sum_evt_i(sum_evt),
    .sum_ok_i(sum_ok), .id_evt_i(id_evt), .id_ok_i(id_ok),
    .go_o(go), .go_op_o(go_op), .stat_o(stat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic logic [7:0] apply_evt(input logic [7:0] s, input int kind, input logic ok);
    logic [7:0] r = s;
    case (kind)
      0: r[7] = 1'b1;
      1: r[4] = ok;
      default: r[3:2] = ok ? 2'b11 : 2'b01;
    endcase
    return r;
  endfunction

  function automatic logic prot_pass(input logic [7:0] op, input logic [7:0] s);
    return (op == OP_OPEN) || (s[3:2] == 2'b11);
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive at negedge; return at the negedge after the accepting edge
  task automatic send(input logic [7:0] b);
    cmd_valid = 1'b1;
    cmd_data  = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic evt(input int kind, input logic ok);
    upd     = (kind == 0);
    sum_evt = (kind == 1);
    id_evt  = (kind == 2);
    sum_ok  = ok;
    id_ok   = ok;
    @(negedge clk);
    upd = 0; sum_evt = 0; id_evt = 0;
    exp_stat = apply_evt(exp_stat, kind, ok);
    case (kind)
      0: chk("R3 upd", stat, exp_stat);
      1: chk("R4 sum", stat, exp_stat);
      default: chk("R5 id", stat, exp_stat);
    endcase
  endtask

  task automatic do_read(input logic [7:0] p, input int stall);
    logic [7:0] es;
    es   = exp_stat;
    prim = p;
    send(OP_RD);
    prim = ~p;
    chk("R6 first valid", st_valid, 1);
    chk("R6 ready low", cmd_ready, 0);
    chk("R6 primary byte", st_data, p);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R11 hold valid", st_valid, 1);
      chk("R11 hold data", st_data, p);
    end
    st_ready = 1'b1;
    @(negedge clk);
    chk("R6 second valid", st_valid, 1);
    chk("R6 status byte", st_data, es);
    @(negedge clk);
    st_ready = 1'b0;
    chk("R6 done", st_valid, 0);
    chk("R6 ready back", cmd_ready, 1);
  endtask

  task automatic clear_cmd(input logic with_evt);
    if (with_evt) begin upd = 1; sum_evt = 1; sum_ok = 1; id_evt = 1; id_ok = 1; end
    send(OP_CLR);
    upd = 0; sum_evt = 0; id_evt = 0;
    exp_stat = '0;
    chk("R7 clear", stat, 8'h00);
  endtask

  // full data command with random gaps below the timeout
  task automatic data_cmd(input logic [7:0] op);
    logic ok;
    ok = prot_pass(op, exp_stat);
    send(op);
    chk("R8 no early go", go, 0);
    if (!ok) begin
      do_read(8'h3C, 0); // R9: next byte decoded as a command
      return;
    end
    for (int i = 0; i < PAY; i++) begin
      tick($urandom_range(0, TMO - 1));
      send(8'($urandom()));
      if (i == PAY - 1) begin
        chk("R8 go", go, 1);
        chk("R8 go op", go_op, op);
      end else chk("R8 no go mid", go, 0);
    end
    @(negedge clk);
    chk("R8 go one cycle", go, 0);
    chk("R10 no tmo", stat, exp_stat);
  endtask

  task automatic tmo_cmd(input logic [7:0] op, input int nb);
    if (!prot_pass(op, exp_stat)) begin
      send(op);
      chk("R9 refused no go", go, 0);
      do_read(8'h11, 0);
      return;
    end
    send(op);
    for (int i = 0; i < nb; i++) send(8'($urandom()));
    tick(TMO - 1);
    chk("R10 before limit", stat, exp_stat);
    tick(1);
    exp_stat[1] = 1'b1;
    chk("R10 at limit", stat, exp_stat);
    chk("R10 no go", go, 0);
    do_read(8'h22, 0); // back in command wait
  endtask

  initial begin
    #500000;
    errs++; checks++;
    $display("FAIL watchdog act=1 exp=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    tick(3);
    chk("R1 por zero", stat, 8'h00);
    por_n = 1'b1;
    rst_n = 1'b1;
    tick(2);
    chk("R1 after por", stat, 8'h00);
    chk("R1 idle valid", st_valid, 0);
    chk("R1 ready", cmd_ready, 1);

    // idle in command wait never times out (R10)
    tick(3 * TMO);
    chk("R10 idle cmd wait", stat, 8'h00);

    evt(0, 1);
    evt(1, 1);
    evt(1, 0);
    evt(2, 0);
    evt(2, 1);
    do_read(8'hA5, 3);

    clear_cmd(1'b1);

    // protected refused, open accepted (R9, R8)
    data_cmd(8'h41);
    data_cmd(OP_OPEN);

    // timeout boundary: byte in the last idle cycle wins (R10)
    evt(2, 1);
    send(8'h41);
    send(8'h01);
    tick(TMO - 1);
    send(8'h02);
    chk("R10 byte wins", stat, exp_stat);
    tick(TMO - 1);
    chk("R10 still clear", stat[1], 0);
    tick(1);
    exp_stat[1] = 1'b1;
    chk("R10 flag set", stat, exp_stat);
    chk("R10 dropped", go, 0);
    do_read(8'h5A, 1);

    // warm reset mid-payload with a clear presented (R2)
    send(8'h41);
    rst_n = 1'b0;
    cmd_valid = 1'b1;
    cmd_data = OP_CLR;
    tick(3);
    chk("R2 held in reset", stat, exp_stat);
    cmd_valid = 1'b0;
    rst_n = 1'b1;
    tick(2);
    chk("R2 kept", stat, exp_stat);
    do_read(8'h77, 0);

    // constrained random mix
    for (int it = 0; it < 150; it++) begin
      int op;
      logic [7:0] opc;
      op = $urandom_range(0, 7);
      opc = ($urandom_range(0, 3) == 0) ? OP_OPEN : 8'($urandom());
      if (opc == OP_RD || opc == OP_CLR) opc = 8'h41;
      case (op)
        0: evt(0, 1);
        1: evt(1, 1'($urandom()));
        2: evt(2, ($urandom_range(0, 3) != 0));
        3: do_read(8'($urandom()), $urandom_range(0, 3));
        4: clear_cmd(1'($urandom()));
        5: data_cmd(opc);
        6: tmo_cmd(opc, $urandom_range(0, PAY - 1));
        default: begin
          tick($urandom_range(1, 2 * TMO));
          chk("R10 idle random", stat, exp_stat);
        end
      endcase
    end

    por_n = 1'b0;
    tick(1);
    chk("R1 por again", stat, 8'h00);
    finish_run();
  end
endmodule